// File: doc/BRIEF.md
# Intensity-Weighted Edge-Preserving Smoother

This block filters the centre pixel of a 3x3 neighbourhood with a mask that is rebuilt for every window. Each of the nine pixels gets a weight that shrinks steeply as its brightness moves away from the centre pixel. Pixels on the far side of an edge therefore contribute little or nothing, and smoothing runs along edges instead of blurring across them. The block sits downstream of a window generator and an edge classifier. It takes a full window together with a one-bit edge flag for the centre pixel.

The weight of a tap is the complement of its distance from the centre (255 minus the distance), raised to the eighth power. The power is formed by three squarings in a row, and each squaring keeps only the upper byte of its 16-bit product. The pixel-times-weight products and the weights are summed at full width, and a pipelined restoring divider forms the normalised result. The filtered value reaches the output only for pixels that are flagged as edges. Every other pixel passes through unchanged. One window is accepted on every clock, and each result appears a fixed twelve cycles later.

Top module: `edp_smoother`

## Requirements
- R1: Tap i of the window occupies bits [8i+7:8i] of `win_i`, and tap 4 is the centre. Each tap's weight starts from a = 255 - |tap - centre|. The block then squares a three times, and after each squaring it keeps bits [15:8] of the 16-bit product. For example, a neighbour 10 levels from the centre gets weight 177, and the centre itself always gets 248.
- R2: A window presented at one rising edge produces its result on `pix_o` right after the 12th rising edge, counting that edge as the first. A new window is accepted on every cycle, and consecutive windows do not disturb each other.
- R3: When `edge_i` is 0, `pix_o` equals the centre pixel of that window.
- R4: When `edge_i` is 1 and all nine taps are equal, `pix_o` equals that value.
- R5: A neighbour 128 or more levels away from the centre has weight 0, while a neighbour 127 levels away has weight 1. If every neighbour is at least 128 levels away, a flagged pixel comes out as its own centre value.
- R6: When `edge_i` is 1, `pix_o` is floor(sum(tap x weight) / sum(weight)), computed without truncating the sums. If the quotient exceeds 255 it is clamped to 255. If the weight sum is zero, the output is the centre pixel.
- R7: When `edge_i` is 1, `pix_o` lies between the smallest and the largest tap value of its window.
- R8: While `rst_n` is low, `pix_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| win_i | input | 72 | Nine 8-bit taps of the 3x3 window, with tap i at bits [8i+7:8i] and the centre at tap 4 |
| edge_i | input | 1 | Edge flag of the centre pixel; 1 selects the filtered value |
| pix_o | output | 8 | Output pixel, 12 cycles after its window |

## Verification
The hardest point to reach from the ports is the boundary where a neighbour's weight drops from one to zero. This happens between distances 127 and 128. A neighbour at distance 127 shifts a bright centre down by exactly one level, while a neighbour at distance 128 leaves it untouched. The stimulus sets a centre of 200 against neighbours at 72, and then one neighbour at 73 with the rest at 0. This separates the two cases. A separate test sends back-to-back windows with mixed edge flags and with neighbours kept close to the centre. These windows yield non-trivial weights, and the test shows that results neither skip nor repeat in the pipeline.

// File: rtl/edp_pkg.sv
package edp_pkg;

  // Default geometry of the smoother
  localparam int unsigned EDP_PIX_W     = 8;
  localparam int unsigned EDP_TAPS      = 9;
  localparam int unsigned EDP_SQUARINGS = 3;  // weight = base^(2^EDP_SQUARINGS)
  localparam int unsigned EDP_DIV_STEP  = 2;  // quotient bits per divider stage
  localparam int unsigned EDP_GRP       = 3;  // taps per partial-sum group

  // Selection made by the output stage
  typedef enum logic [1:0] {
    SEL_CENTRE = 2'd0,
    SEL_QUOT   = 2'd1,
    SEL_SAT    = 2'd2
  } edp_sel_e;

endpackage

// File: rtl/edp_delay.sv
module edp_delay #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] d_o
);

  logic [DEPTH-1:0][WIDTH-1:0] sh_nx;
  logic [DEPTH-1:0][WIDTH-1:0] sh_q;

  always_comb begin
    sh_nx[0] = d_i;
    for (int i = 1; i < int'(DEPTH); i++) begin
      sh_nx[i] = sh_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_nx;
    end
  end

  assign d_o = sh_q[DEPTH-1];

endmodule

// File: rtl/edp_weight.sv
module edp_weight #(
  parameter int unsigned PIX_W     = 8,
  parameter int unsigned TAPS      = 9,
  parameter int unsigned SQUARINGS = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [TAPS-1:0][PIX_W-1:0]  pix_i,
  output logic [TAPS-1:0][PIX_W-1:0]  w_o,
  output logic [TAPS-1:0][PIX_W-1:0]  pix_o
);

  localparam int unsigned        CTR  = TAPS / 2;
  localparam logic [PIX_W-1:0]   FULL = '1;

  // Stage 1: absolute intensity distance to the centre
  logic [TAPS-1:0][PIX_W-1:0] dist_nx;
  logic [TAPS-1:0][PIX_W-1:0] dist_q;
  logic [TAPS-1:0][PIX_W-1:0] pix_q;

  always_comb begin
    for (int t = 0; t < int'(TAPS); t++) begin
      if (pix_i[t] >= pix_i[CTR]) begin
        dist_nx[t] = pix_i[t] - pix_i[CTR];
      end else begin
        dist_nx[t] = pix_i[CTR] - pix_i[t];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dist_q <= '0;
      pix_q  <= '0;
    end else begin
      dist_q <= dist_nx;
      pix_q  <= pix_i;
    end
  end

  // Stages 2..SQUARINGS+1: repeated squaring keeping the upper half
  for (genvar k = 0; k < int'(SQUARINGS); k++) begin : g_sq
    logic [TAPS-1:0][PIX_W-1:0] base;
    logic [TAPS-1:0][PIX_W-1:0] sq_nx;
    logic [TAPS-1:0][PIX_W-1:0] sq_q;
    logic [TAPS-1:0][PIX_W-1:0] pd_q;

    if (k == 0) begin : g_first
      always_comb begin
        for (int t = 0; t < int'(TAPS); t++) begin
          base[t] = FULL - dist_q[t];
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pd_q <= '0;
        else        pd_q <= pix_q;
      end
    end else begin : g_next
      always_comb base = g_sq[k-1].sq_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pd_q <= '0;
        else        pd_q <= g_sq[k-1].pd_q;
      end
    end

    always_comb begin
      logic [2*PIX_W-1:0] prod;
      for (int t = 0; t < int'(TAPS); t++) begin
        prod     = {{PIX_W{1'b0}}, base[t]} * {{PIX_W{1'b0}}, base[t]};
        sq_nx[t] = prod[2*PIX_W-1:PIX_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sq_q <= '0;
      else        sq_q <= sq_nx;
    end
  end

  assign w_o   = g_sq[SQUARINGS-1].sq_q;
  assign pix_o = g_sq[SQUARINGS-1].pd_q;

endmodule

// File: rtl/edp_mac.sv
module edp_mac #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned TAPS  = 9,
  parameter int unsigned GRP   = 3
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [TAPS-1:0][PIX_W-1:0]             pix_i,
  input  logic [TAPS-1:0][PIX_W-1:0]             w_i,
  output logic [2*PIX_W+$clog2(TAPS)-1:0]        num_o,
  output logic [PIX_W+$clog2(TAPS)-1:0]          den_o
);

  localparam int unsigned LOGT  = $clog2(TAPS);
  localparam int unsigned NUM_W = 2*PIX_W + LOGT;
  localparam int unsigned DEN_W = PIX_W + LOGT;
  localparam int unsigned NGRP  = (TAPS + GRP - 1) / GRP;

  // Stage A: full-width products
  logic [TAPS-1:0][2*PIX_W-1:0] prod_nx, prod_q;
  logic [TAPS-1:0][PIX_W-1:0]   w_q;

  always_comb begin
    for (int t = 0; t < int'(TAPS); t++) begin
      prod_nx[t] = {{PIX_W{1'b0}}, pix_i[t]} * {{PIX_W{1'b0}}, w_i[t]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      w_q    <= '0;
    end else begin
      prod_q <= prod_nx;
      w_q    <= w_i;
    end
  end

  // Stage B: partial sums per group
  logic [NGRP-1:0][NUM_W-1:0] pnum_nx, pnum_q;
  logic [NGRP-1:0][DEN_W-1:0] pden_nx, pden_q;

  always_comb begin
    pnum_nx = '0;
    pden_nx = '0;
    for (int t = 0; t < int'(TAPS); t++) begin
      pnum_nx[t/int'(GRP)] = pnum_nx[t/int'(GRP)] + NUM_W'(prod_q[t]);
      pden_nx[t/int'(GRP)] = pden_nx[t/int'(GRP)] + DEN_W'(w_q[t]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pnum_q <= '0;
      pden_q <= '0;
    end else begin
      pnum_q <= pnum_nx;
      pden_q <= pden_nx;
    end
  end

  // Stage C: final sums
  logic [NUM_W-1:0] num_nx, num_q;
  logic [DEN_W-1:0] den_nx, den_q;

  always_comb begin
    num_nx = '0;
    den_nx = '0;
    for (int g = 0; g < int'(NGRP); g++) begin
      num_nx = num_nx + pnum_q[g];
      den_nx = den_nx + pden_q[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q <= '0;
      den_q <= '0;
    end else begin
      num_q <= num_nx;
      den_q <= den_nx;
    end
  end

  assign num_o = num_q;
  assign den_o = den_q;

endmodule

// File: rtl/edp_div.sv
module edp_div #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned TAPS  = 9,
  parameter int unsigned STEP  = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [2*PIX_W+$clog2(TAPS)-1:0]   num_i,
  input  logic [PIX_W+$clog2(TAPS)-1:0]     den_i,
  output logic [PIX_W-1:0]                  quo_o,
  output logic                              ovf_o,
  output logic                              zero_o
);

  localparam int unsigned LOGT  = $clog2(TAPS);
  localparam int unsigned NUM_W = 2*PIX_W + LOGT;
  localparam int unsigned DEN_W = PIX_W + LOGT;
  localparam int unsigned NSTG  = PIX_W / STEP;

  for (genvar s = 0; s < int'(NSTG); s++) begin : g_st
    logic [DEN_W-1:0] r_in, r_nx, r_q, d_in, d_q;
    logic [PIX_W-1:0] l_in, l_nx, l_q, q_in, q_nx, q_q;
    logic             ovf_in, ovf_q, z_in, z_q;

    if (s == 0) begin : g_entry
      always_comb begin
        r_in   = num_i[NUM_W-1:PIX_W];
        l_in   = num_i[PIX_W-1:0];
        q_in   = '0;
        d_in   = den_i;
        ovf_in = (num_i[NUM_W-1:PIX_W] >= den_i);
        z_in   = (den_i == '0);
      end
    end else begin : g_chain
      always_comb begin
        r_in   = g_st[s-1].r_q;
        l_in   = g_st[s-1].l_q;
        q_in   = g_st[s-1].q_q;
        d_in   = g_st[s-1].d_q;
        ovf_in = g_st[s-1].ovf_q;
        z_in   = g_st[s-1].z_q;
      end
    end

    // STEP restoring iterations
    always_comb begin
      logic [DEN_W:0]   trial;
      logic [DEN_W-1:0] r;
      logic [PIX_W-1:0] l;
      logic [PIX_W-1:0] q;
      r = r_in;
      l = l_in;
      q = q_in;
      for (int i = 0; i < int'(STEP); i++) begin
        trial = {r, l[PIX_W-1]};
        l     = {l[PIX_W-2:0], 1'b0};
        if (trial >= {1'b0, d_in}) begin
          trial = trial - {1'b0, d_in};
          q     = {q[PIX_W-2:0], 1'b1};
        end else begin
          q     = {q[PIX_W-2:0], 1'b0};
        end
        r = trial[DEN_W-1:0];
      end
      r_nx = r;
      l_nx = l;
      q_nx = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r_q   <= '0;
        l_q   <= '0;
        q_q   <= '0;
        d_q   <= '0;
        ovf_q <= 1'b0;
        z_q   <= 1'b0;
      end else begin
        r_q   <= r_nx;
        l_q   <= l_nx;
        q_q   <= q_nx;
        d_q   <= d_in;
        ovf_q <= ovf_in;
        z_q   <= z_in;
      end
    end
  end

  assign quo_o  = g_st[NSTG-1].q_q;
  assign ovf_o  = g_st[NSTG-1].ovf_q;
  assign zero_o = g_st[NSTG-1].z_q;

endmodule

// File: rtl/edp_smoother.sv
module edp_smoother
  import edp_pkg::*;
#(
  parameter int unsigned PIX_W     = EDP_PIX_W,
  parameter int unsigned TAPS      = EDP_TAPS,
  parameter int unsigned SQUARINGS = EDP_SQUARINGS,
  parameter int unsigned DIV_STEP  = EDP_DIV_STEP,
  parameter int unsigned GRP       = EDP_GRP
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [TAPS*PIX_W-1:0]   win_i,
  input  logic                    edge_i,
  output logic [PIX_W-1:0]        pix_o
);

  localparam int unsigned LOGT     = $clog2(TAPS);
  localparam int unsigned NUM_W    = 2*PIX_W + LOGT;
  localparam int unsigned DEN_W    = PIX_W + LOGT;
  localparam int unsigned CTR      = TAPS / 2;
  localparam int unsigned W_LAT    = 1 + SQUARINGS;
  localparam int unsigned MAC_LAT  = 3;
  localparam int unsigned DIV_LAT  = PIX_W / DIV_STEP;
  localparam int unsigned LAT      = W_LAT + MAC_LAT + DIV_LAT + 1;
  localparam int unsigned SIDE_DLY = LAT - 1;

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [TAPS-1:0][PIX_W-1:0] taps;
  assign taps = win_i;

  // Weight generation
  logic [TAPS-1:0][PIX_W-1:0] w_s, pix_s;

  edp_weight #(.PIX_W(PIX_W), .TAPS(TAPS), .SQUARINGS(SQUARINGS)) u_weight (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .pix_i (taps),
    .w_o   (w_s),
    .pix_o (pix_s)
  );

  // Weighted sums
  logic [NUM_W-1:0] num_s;
  logic [DEN_W-1:0] den_s;

  edp_mac #(.PIX_W(PIX_W), .TAPS(TAPS), .GRP(GRP)) u_mac (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .pix_i (pix_s),
    .w_i   (w_s),
    .num_o (num_s),
    .den_o (den_s)
  );

  // Normalisation
  logic [PIX_W-1:0] quo_s;
  logic             ovf_s, zero_s;

  edp_div #(.PIX_W(PIX_W), .TAPS(TAPS), .STEP(DIV_STEP)) u_div (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .num_i  (num_s),
    .den_i  (den_s),
    .quo_o  (quo_s),
    .ovf_o  (ovf_s),
    .zero_o (zero_s)
  );

  // Edge flag and centre pixel travel alongside the datapath
  logic [PIX_W:0] side_s;
  logic           side_edge;
  logic [PIX_W-1:0] side_ctr;

  edp_delay #(.WIDTH(PIX_W+1), .DEPTH(SIDE_DLY)) u_side (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   ({edge_i, taps[CTR]}),
    .d_o   (side_s)
  );

  assign side_edge = side_s[PIX_W];
  assign side_ctr  = side_s[PIX_W-1:0];

  // Output stage
  edp_sel_e         sel;
  logic [PIX_W-1:0] pix_nx, pix_q;

  always_comb begin
    if (!side_edge || zero_s) begin
      sel = SEL_CENTRE;
    end else if (ovf_s) begin
      sel = SEL_SAT;
    end else begin
      sel = SEL_QUOT;
    end
    case (sel)
      SEL_QUOT: pix_nx = quo_s;
      SEL_SAT:  pix_nx = '1;
      default:  pix_nx = side_ctr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pix_q <= '0;
    end else begin
      pix_q <= pix_nx;
    end
  end

  assign pix_o = pix_q;

endmodule

// File: rtl/edp_smoother_chk.sv
module edp_smoother_chk #(
  parameter int unsigned PIX_W     = 8,
  parameter int unsigned TAPS      = 9,
  parameter int unsigned SQUARINGS = 3,
  parameter int unsigned LAT       = 12
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [TAPS*PIX_W-1:0] win_i,
  input logic                  edge_i,
  input logic [PIX_W-1:0]      pix_o
);

  localparam int unsigned CTR = TAPS / 2;
  localparam int unsigned CW  = $clog2(LAT + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(LAT);

  // Smallest distance whose weight truncates to zero
  function automatic int far_limit();
    int maxv;
    int lim;
    maxv = (1 << PIX_W) - 1;
    lim  = maxv + 1;
    for (int a = 0; a <= maxv; a++) begin
      int s;
      s = a;
      for (int k = 0; k < int'(SQUARINGS); k++) s = (s * s) >> PIX_W;
      if (s == 0) lim = maxv - a;
    end
    return lim;
  endfunction

  localparam int FAR_D = far_limit();

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt != CNT_MAX) begin
      cnt <= cnt + CW'(1);
    end
  end

  logic [PIX_W-1:0] ctr, mn, mx;
  logic             uni, far;

  always_comb begin
    ctr = win_i[CTR*PIX_W +: PIX_W];
    mn  = ctr;
    mx  = ctr;
    uni = 1'b1;
    far = 1'b1;
    for (int t = 0; t < int'(TAPS); t++) begin
      logic [PIX_W-1:0] p;
      int d;
      p = win_i[t*PIX_W +: PIX_W];
      if (p < mn) mn = p;
      if (p > mx) mx = p;
      if (p != ctr) uni = 1'b0;
      d = (p > ctr) ? int'(p) - int'(ctr) : int'(ctr) - int'(p);
      if (t != int'(CTR) && d < FAR_D) far = 1'b0;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> pix_o == '0) else $error("output not idle in reset"); // R8

  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !$past(edge_i, LAT)) |-> pix_o == $past(ctr, LAT))
    else $error("unflagged pixel altered"); // R3

  AST_UNIFORM_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && $past(edge_i, LAT) && $past(uni, LAT)) |-> pix_o == $past(ctr, LAT))
    else $error("flat window altered"); // R4

  AST_FAR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && $past(edge_i, LAT) && $past(far, LAT)) |-> pix_o == $past(ctr, LAT))
    else $error("distant neighbours contributed"); // R5

  AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && $past(edge_i, LAT)) |->
      (pix_o >= $past(mn, LAT) && pix_o <= $past(mx, LAT)))
    else $error("filtered value outside window range"); // R7

endmodule

bind edp_smoother edp_smoother_chk #(
  .PIX_W(PIX_W), .TAPS(TAPS), .SQUARINGS(SQUARINGS), .LAT(LAT)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .win_i  (win_i),
  .edge_i (edge_i),
  .pix_o  (pix_o)
);

// File: tb/edp_smoother_tb.sv
module edp_smoother_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 12;
  localparam int NSTREAM    = 48;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [71:0] win;
  logic        edge_f;
  logic [7:0]  pix_o;

  int n_chk = 0;
  int n_err = 0;
  int unsigned seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  edp_smoother u_dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .win_i  (win),
    .edge_i (edge_f),
    .pix_o  (pix_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [71:0] mk(input int c, input int n[8]);
    logic [71:0] w;
    int k;
    k = 0;
    for (int t = 0; t < 9; t++) begin
      if (t == 4) w[t*8 +: 8] = c[7:0];
      else begin
        w[t*8 +: 8] = n[k][7:0];
        k++;
      end
    end
    return w;
  endfunction

  // Expected value from the requirement formulas
  function automatic int model(input logic [71:0] w, input bit ez);
    int c, num, den, q;
    c   = int'(w[32 +: 8]);
    num = 0;
    den = 0;
    for (int t = 0; t < 9; t++) begin
      int p, d, a;
      p = int'(w[t*8 +: 8]);
      d = (p > c) ? p - c : c - p;
      a = 255 - d;
      for (int k = 0; k < 3; k++) a = (a * a) >> 8;
      num += p * a;
      den += a;
    end
    if (!ez || den == 0) return c;
    q = num / den;
    if (q > 255) q = 255;
    return q;
  endfunction

  function automatic int next_rand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed >> 8);
  endfunction

  task automatic run_one(input logic [71:0] w, input bit ez, input string req,
                         input string what, input int exp);
    @(negedge clk);
    win    = w;
    edge_f = ez;
    repeat (LAT) @(negedge clk);
    check(req, what, int'(pix_o), exp);
  endtask

  task automatic t_reset();
    rst_n  = 1'b0;
    win    = {9{8'hA5}};
    edge_f = 1'b1;
    repeat (4) @(negedge clk);
    check("R8", "output held at zero in reset", int'(pix_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_pass();
    int n1[8] = '{10, 250, 3, 99, 180, 77, 0, 255};
    int n2[8] = '{61, 62, 63, 64, 66, 67, 68, 69};
    run_one(mk(140, n1), 1'b0, "R3", "unflagged mixed window", 140);
    run_one(mk(65, n2), 1'b0, "R3", "unflagged near window", 65);
  endtask

  task automatic t_uniform();
    int v[3] = '{77, 255, 0};
    foreach (v[i]) begin
      int n[8];
      foreach (n[k]) n[k] = v[i];
      run_one(mk(v[i], n), 1'b1, "R4", "flat window", v[i]);
    end
  endtask

  task automatic t_far();
    int n_far[8]  = '{72, 72, 72, 72, 72, 72, 72, 72};
    int n_edge[8] = '{73, 0, 0, 0, 0, 0, 0, 0};
    int n_dark[8] = '{255, 255, 255, 255, 255, 255, 255, 255};
    // distance 128 on every neighbour: no contribution
    run_one(mk(200, n_far), 1'b1, "R5", "neighbours at distance 128", 200);
    // one neighbour at distance 127 (weight 1): (200*248+73)/249 = 199
    run_one(mk(200, n_edge), 1'b1, "R5", "one neighbour at distance 127", 199);
    run_one(mk(0, n_dark), 1'b1, "R5", "dark centre, bright ring", 0);
  endtask

  task automatic t_weights();
    int up[8] = '{110, 110, 110, 110, 110, 110, 110, 110};
    int dn[8] = '{90, 90, 90, 90, 90, 90, 90, 90};
    int mix[8] = '{95, 105, 120, 80, 101, 99, 140, 60};
    // weights 248 (centre) and 177 (distance 10): 180560/1664 = 108
    run_one(mk(100, up), 1'b1, "R1", "ring 10 above centre", 108);
    // 152240/1664 = 91
    run_one(mk(100, dn), 1'b1, "R1", "ring 10 below centre", 91);
    run_one(mk(100, mix), 1'b1, "R6", "mixed distances", model(mk(100, mix), 1'b1));
  endtask

  task automatic t_latency();
    int n[8] = '{1, 2, 3, 4, 5, 6, 7, 8};
    @(negedge clk);
    win    = mk(10, n);
    edge_f = 1'b0;
    repeat (LAT + 2) @(negedge clk);
    win = mk(90, n);
    @(negedge clk);
    win = mk(10, n);
    repeat (LAT - 2) @(negedge clk);
    check("R2", "cycle 11 still previous", int'(pix_o), 10);
    @(negedge clk);
    check("R2", "cycle 12 new result", int'(pix_o), 90);
    @(negedge clk);
    check("R2", "cycle 13 single pulse", int'(pix_o), 10);
  endtask

  task automatic t_stream();
    logic [71:0] sw[NSTREAM];
    bit          se[NSTREAM];
    for (int j = 0; j < NSTREAM; j++) begin
      int c, r;
      c = next_rand() & 255;
      r = next_rand();
      for (int t = 0; t < 9; t++) begin
        int p;
        if (t == 4) p = c;
        else if (r[t]) p = next_rand() & 255;
        else begin
          p = c + (next_rand() % 41) - 20;
          if (p < 0) p = 0;
          if (p > 255) p = 255;
        end
        sw[j][t*8 +: 8] = p[7:0];
      end
      se[j] = (j % 4 != 3);
    end
    for (int j = 0; j < NSTREAM + LAT; j++) begin
      @(negedge clk);
      if (j >= LAT) begin
        int mn, mx, e;
        e = model(sw[j-LAT], se[j-LAT]);
        check(se[j-LAT] ? "R6" : "R3", "streamed window", int'(pix_o), e);
        mn = 255;
        mx = 0;
        for (int t = 0; t < 9; t++) begin
          int p;
          p = int'(sw[j-LAT][t*8 +: 8]);
          if (p < mn) mn = p;
          if (p > mx) mx = p;
        end
        check("R7", "within window range", int'(pix_o >= mn[7:0] && pix_o <= mx[7:0]), 1);
      end
      if (j < NSTREAM) begin
        win    = sw[j];
        edge_f = se[j];
      end
    end
  endtask

  initial begin
    t_reset();
    t_pass();
    t_uniform();
    t_far();
    t_weights();
    t_latency();
    t_stream();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule